// File: doc/BRIEF.md
# Lowest-Priority Interrupt Router

This block takes a set of external interrupt request lines and turns each request into a single delivery strobe aimed at exactly one of several processors. Every request line has its own configuration entry: the vector the processor will receive, a mask bit, a trigger type (edge or level), a delivery mode and a destination field. In fixed mode the destination names one processor by index. In lowest-priority mode the destination is a bitmask of eligible processors. The router then compares the live current-priority values that the processors report and picks the eligible processor with the smallest value.

Deliveries are one-cycle strobes on a per-processor output, with the vector on a shared bus. A request never reaches more than one processor, so only one handler runs for it. Level-triggered lines are held off after delivery until the receiving processor reports an end-of-interrupt carrying the matching vector. Vector numbers may be reused by entries that target different processors. Requests that have no valid target are dropped and flagged. A parameter selects how ties on the lowest priority are broken: either the lowest-numbered processor wins, or a rotating pointer spreads tied deliveries across the group.

Top module: `lp_irq_router`

## Requirements
- R1: After reset every entry is masked, edge-triggered and in fixed mode, and `dlv_o`, `dlv_vec_o` and `err_o` are all zero. A write with `cfg_we_i` high replaces the entry selected by `cfg_idx_i` at the next clock edge and discards that entry's pending and in-service state.
- R2: In fixed mode (`cfg_lowp_i`=0), a request on an unmasked line is delivered to processor `cfg_dest_i`. The strobe bit `dlv_o[cfg_dest_i]` is high, with `dlv_vec_o` equal to the entry's vector, in the cycle that follows the clock edge at which the request is first seen.
- R3: In lowest-priority mode (`cfg_lowp_i`=1), bit c of `cfg_dest_i` marks processor c as eligible. The request goes to the eligible processor whose field `cpu_prio_i[c*PRIO_W +: PRIO_W]` holds the numerically smallest value, and the values are sampled at the edge where the delivery is decided.
- R4: On a tie for the lowest value, with ROTATE=0 the lowest-numbered tied processor wins. With ROTATE=1 the first tied processor at or after a pointer wins, scanning upward with wrap-around. The pointer resets to 0 and moves to the winner plus one, modulo NUM_CPU, after each lowest-priority delivery.
- R5: At most one bit of `dlv_o` is high in any cycle, and each strobe lasts one cycle. When no strobe is high, `dlv_vec_o` is zero.
- R6: A masked line never produces a delivery. Rising edges seen while an edge-triggered line is masked are discarded and are not delivered after unmasking.
- R7: A request that has no valid target is dropped. This happens in fixed mode when the index is NUM_CPU or higher, and in lowest-priority mode when no bit below NUM_CPU is set in the mask. A dropped request produces no strobe and raises `err_o` for one cycle.
- R8: After a level-triggered line is delivered, it is not delivered again until `eoi_i` is pulsed with `eoi_cpu_i` equal to the receiving processor and `eoi_vec_i` equal to its vector. If the line is still high after that end-of-interrupt, it is delivered again.
- R9: An edge-triggered line is delivered once per rising edge, however long it is held high.
- R10: When several lines are ready in the same cycle, the lowest-numbered line is delivered first and the others follow in later cycles in ascending order.
- R11: Entries that target different processors may share a vector. An end-of-interrupt releases only the entry whose processor and vector both match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IRQ_W | Entry to write |
| cfg_vec_i | input | VEC_W | Vector for the entry |
| cfg_mask_i | input | 1 | 1 masks the line |
| cfg_lowp_i | input | 1 | 0 fixed, 1 lowest-priority |
| cfg_level_i | input | 1 | 0 edge, 1 level trigger |
| cfg_dest_i | input | DEST_W | Processor index or eligibility mask |
| cpu_prio_i | input | NUM_CPU*PRIO_W | Current priority per processor, processor c at bits c*PRIO_W |
| eoi_i | input | 1 | End-of-interrupt pulse |
| eoi_cpu_i | input | CPU_W | Processor reporting end-of-interrupt |
| eoi_vec_i | input | VEC_W | Vector being completed |
| dlv_o | output | NUM_CPU | One-cycle delivery strobe per processor |
| dlv_vec_o | output | VEC_W | Vector of the current delivery |
| err_o | output | 1 | One-cycle flag for a dropped request |

## Verification
The bench builds two copies with the default sizes: 24 lines, 4 processors, 4-bit priorities, 8-bit vectors and destinations. One copy uses ROTATE=0 and the other ROTATE=1, and both are driven by the same stimulus. With four processors and an 8-bit destination, out-of-range fixed indices and masks with only high bits set can both be reached, which exercises the drop path. Running the two tie policies side by side shows the rotating pointer wrapping past processor 3, while the fixed policy keeps choosing processor 0. Shared vectors between two level entries show that an end-of-interrupt releases only the entry it matches.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  typedef enum logic {DLV_FIXED = 1'b0, DLV_LOWEST = 1'b1} dlv_mode_e;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/lpr_cfg_regs.sv
module lpr_cfg_regs #(
  parameter int NUM_IRQ = 24,
  parameter int VEC_W   = 8,
  parameter int DEST_W  = 8,
  parameter int IRQ_W   = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [IRQ_W-1:0]                  idx_i,
  input  logic [VEC_W-1:0]                  vec_i,
  input  logic                              mask_i,
  input  logic                              lowp_i,
  input  logic                              level_i,
  input  logic [DEST_W-1:0]                 dest_i,
  output logic [NUM_IRQ-1:0]                wr_hit_o,
  output logic [NUM_IRQ-1:0][VEC_W-1:0]     vec_o,
  output logic [NUM_IRQ-1:0]                mask_o,
  output logic [NUM_IRQ-1:0]                lowp_o,
  output logic [NUM_IRQ-1:0]                level_o,
  output logic [NUM_IRQ-1:0][DEST_W-1:0]    dest_o
);
  import lpr_pkg::*;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ent
    dlv_mode_e mode_q;
    trig_e     trig_q;

    assign wr_hit_o[i] = we_i && (idx_i == IRQ_W'(i));
    assign lowp_o[i]   = (mode_q == DLV_LOWEST);
    assign level_o[i]  = (trig_q == TRIG_LEVEL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vec_o[i]  <= '0;
        mask_o[i] <= 1'b1;
        mode_q    <= DLV_FIXED;
        trig_q    <= TRIG_EDGE;
        dest_o[i] <= '0;
      end else if (wr_hit_o[i]) begin
        vec_o[i]  <= vec_i;
        mask_o[i] <= mask_i;
        mode_q    <= lowp_i ? DLV_LOWEST : DLV_FIXED;
        trig_q    <= level_i ? TRIG_LEVEL : TRIG_EDGE;
        dest_o[i] <= dest_i;
      end
    end
  end
endmodule

// File: rtl/lpr_lowest_pick.sv
module lpr_lowest_pick #(
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4,
  parameter int CPU_W   = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CPU-1:0]               elig_i,
  input  logic [NUM_CPU-1:0][PRIO_W-1:0]   prio_i,
  input  logic [CPU_W-1:0]                 ptr_i,
  output logic                             found_o,
  output logic [CPU_W-1:0]                 win_o
);
  logic [PRIO_W-1:0]  min_v;
  logic [NUM_CPU-1:0] tie;
  logic               done;

  always_comb begin
    min_v = '1;
    for (int c = 0; c < NUM_CPU; c++)
      if (elig_i[c] && (prio_i[c] < min_v)) min_v = prio_i[c];
    for (int c = 0; c < NUM_CPU; c++)
      tie[c] = elig_i[c] && (prio_i[c] == min_v);
  end

  // scan tied processors starting at the pointer, wrapping
  always_comb begin
    win_o = '0;
    done  = 1'b0;
    for (int k = 0; k < NUM_CPU; k++) begin
      int idx;
      idx = (int'(ptr_i) + k) % NUM_CPU;
      if (!done && tie[idx]) begin
        win_o = CPU_W'(idx);
        done  = 1'b1;
      end
    end
  end

  assign found_o = |elig_i;

  always_ff @(posedge clk_i) begin
    if (rst_ni && found_o) begin
      a_r3_winner_eligible: assert (elig_i[win_o]);
      for (int c = 0; c < NUM_CPU; c++)
        if (elig_i[c]) begin
          a_r3_winner_lowest: assert (prio_i[win_o] <= prio_i[c]);
        end
    end
  end
endmodule

// File: rtl/lp_irq_router.sv
module lp_irq_router #(
  parameter int NUM_IRQ = 24,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 8,
  parameter int DEST_W  = 8,
  parameter bit ROTATE  = 1'b0,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_IRQ-1:0]        irq_i,
  input  logic                      cfg_we_i,
  input  logic [IRQ_W-1:0]          cfg_idx_i,
  input  logic [VEC_W-1:0]          cfg_vec_i,
  input  logic                      cfg_mask_i,
  input  logic                      cfg_lowp_i,
  input  logic                      cfg_level_i,
  input  logic [DEST_W-1:0]         cfg_dest_i,
  input  logic [NUM_CPU*PRIO_W-1:0] cpu_prio_i,
  input  logic                      eoi_i,
  input  logic [CPU_W-1:0]          eoi_cpu_i,
  input  logic [VEC_W-1:0]          eoi_vec_i,
  output logic [NUM_CPU-1:0]        dlv_o,
  output logic [VEC_W-1:0]          dlv_vec_o,
  output logic                      err_o
);
  localparam logic [CPU_W:0] NO_CPU = (CPU_W+1)'(NUM_CPU);

  logic [NUM_IRQ-1:0]              wr_hit, mask_q, lowp_q, level_q;
  logic [NUM_IRQ-1:0][VEC_W-1:0]   vec_q;
  logic [NUM_IRQ-1:0][DEST_W-1:0]  dest_q;

  lpr_cfg_regs #(
    .NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W), .DEST_W(DEST_W), .IRQ_W(IRQ_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .vec_i(cfg_vec_i),
    .mask_i(cfg_mask_i), .lowp_i(cfg_lowp_i), .level_i(cfg_level_i),
    .dest_i(cfg_dest_i), .wr_hit_o(wr_hit), .vec_o(vec_q),
    .mask_o(mask_q), .lowp_o(lowp_q), .level_o(level_q), .dest_o(dest_q)
  );

  logic [NUM_IRQ-1:0]            irq_q, pend_q, svc_q, rise, ready, eoi_hit;
  logic [NUM_IRQ-1:0][CPU_W:0]   svc_cpu_q;

  assign rise = irq_i & ~irq_q;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      ready[i] = !mask_q[i] && !wr_hit[i] &&
                 (level_q[i] ? (irq_i[i] && !svc_q[i]) : (pend_q[i] || rise[i]));
      eoi_hit[i] = eoi_i && svc_q[i] && (svc_cpu_q[i] == {1'b0, eoi_cpu_i}) &&
                   (vec_q[i] == eoi_vec_i);
    end
  end

  // lowest-numbered ready line wins
  logic             sel_found;
  logic [IRQ_W-1:0] sel_idx;
  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (ready[i]) begin
        sel_found = 1'b1;
        sel_idx   = IRQ_W'(i);
      end
  end

  logic [VEC_W-1:0]  vec_s;
  logic [DEST_W-1:0] dest_s;
  logic              lowp_s, level_s;
  assign vec_s   = vec_q[sel_idx];
  assign dest_s  = dest_q[sel_idx];
  assign lowp_s  = lowp_q[sel_idx];
  assign level_s = level_q[sel_idx];

  logic [NUM_CPU-1:0][PRIO_W-1:0] prio_arr;
  logic [CPU_W-1:0]               ptr_q, lp_win, tgt;
  logic                           lp_found, fix_ok, go, drop;
  assign prio_arr = cpu_prio_i;

  lpr_lowest_pick #(.NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .CPU_W(CPU_W)) u_pick (
    .clk_i, .rst_ni,
    .elig_i(dest_s[NUM_CPU-1:0]), .prio_i(prio_arr), .ptr_i(ptr_q),
    .found_o(lp_found), .win_o(lp_win)
  );

  assign fix_ok = dest_s < DEST_W'(NUM_CPU);
  assign tgt    = lowp_s ? lp_win : dest_s[CPU_W-1:0];
  assign go     = sel_found && (lowp_s ? (lp_found && lowp_q[sel_idx]) : fix_ok);
  assign drop   = sel_found && !go;

  if (ROTATE) begin : g_rot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            ptr_q <= '0;
      else if (go && lowp_s)  ptr_q <= (lp_win == CPU_W'(NUM_CPU - 1)) ? '0 : lp_win + 1'b1;
    end
  end else begin : g_fix
    assign ptr_q = '0;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    wire pick = sel_found && (sel_idx == IRQ_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q[i]     <= 1'b0;
        pend_q[i]    <= 1'b0;
        svc_q[i]     <= 1'b0;
        svc_cpu_q[i] <= NO_CPU;
      end else begin
        irq_q[i] <= irq_i[i];
        if (wr_hit[i]) begin
          pend_q[i] <= 1'b0;
          svc_q[i]  <= 1'b0;
        end else if (pick) begin
          pend_q[i] <= 1'b0;
          if (level_s) begin
            svc_q[i]     <= 1'b1;
            svc_cpu_q[i] <= go ? {1'b0, tgt} : NO_CPU; // dropped: wait for rewrite
          end
        end else begin
          if (rise[i] && !mask_q[i] && !level_q[i]) pend_q[i] <= 1'b1;
          if (eoi_hit[i]) svc_q[i] <= 1'b0;
        end
      end
    end

    a_r8_svc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (svc_q[i] && !eoi_hit[i] && !wr_hit[i]) |=> svc_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_o     <= '0;
      dlv_vec_o <= '0;
      err_o     <= 1'b0;
    end else begin
      dlv_o     <= go ? (NUM_CPU'(1) << tgt) : '0;
      dlv_vec_o <= go ? vec_s : '0;
      err_o     <= drop;
    end
  end

  a_r5_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dlv_o));
  a_r7_drop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (dlv_o == '0));
  a_r5_vec_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_o == '0) |-> (dlv_vec_o == '0));
endmodule

// File: tb/lp_irq_router_bench.sv
module lp_irq_router_bench;
  localparam int NI = 24, NC = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] irq = '0;
  logic        we = 1'b0, mask = 1'b1, lowp = 1'b0, level = 1'b0;
  logic [4:0]  idx = '0;
  logic [7:0]  vec = '0, dest = '0, eoi_vec = '0;
  logic [15:0] prio = '0;
  logic        eoi = 1'b0;
  logic [1:0]  eoi_cpu = '0;
  logic [NC-1:0] dlv_a, dlv_b;
  logic [7:0]  vec_a, vec_b;
  logic        err_a, err_b;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lp_irq_router #(.ROTATE(1'b0)) u_lp_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_vec_i(vec), .cfg_mask_i(mask), .cfg_lowp_i(lowp), .cfg_level_i(level),
    .cfg_dest_i(dest), .cpu_prio_i(prio), .eoi_i(eoi), .eoi_cpu_i(eoi_cpu),
    .eoi_vec_i(eoi_vec), .dlv_o(dlv_a), .dlv_vec_o(vec_a), .err_o(err_a));

  lp_irq_router #(.ROTATE(1'b1)) u_lp_irq_router_rot (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_vec_i(vec), .cfg_mask_i(mask), .cfg_lowp_i(lowp), .cfg_level_i(level),
    .cfg_dest_i(dest), .cpu_prio_i(prio), .eoi_i(eoi), .eoi_cpu_i(eoi_cpu),
    .eoi_vec_i(eoi_vec), .dlv_o(dlv_b), .dlv_vec_o(vec_b), .err_o(err_b));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [3:0] ea, input logic [3:0] eb,
                            input logic [7:0] ev, input logic ee);
    chk(req, dlv_a, ea);
    chk(req, dlv_b, eb);
    chk(req, vec_a, ev);
    chk(req, err_a, ee);
    chk(req, err_b, ee);
  endtask

  task automatic wr(input int i, input logic [7:0] v, input logic m, input logic lp,
                    input logic lv, input logic [7:0] d);
    we = 1'b1; idx = 5'(i); vec = v; mask = m; lowp = lp; level = lv; dest = d;
    step();
    we = 1'b0;
  endtask

  task automatic pulse(input string req, input int i, input logic [3:0] ea,
                       input logic [3:0] eb, input logic [7:0] ev);
    irq[i] = 1'b1;
    step();
    expect_out(req, ea, eb, ev, 1'b0);
    irq[i] = 1'b0;
    step();
    expect_out("R5", 4'b0, 4'b0, 8'h00, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) step();
    expect_out("R1", 4'b0, 4'b0, 8'h00, 1'b0);
    rst_n = 1'b1;
    step();
    irq[0] = 1'b1;            // entry 0 is masked after reset
    step();
    expect_out("R1", 4'b0, 4'b0, 8'h00, 1'b0);
    irq[0] = 1'b0;
    step();
  endtask

  task automatic t_fixed();
    wr(1, 8'h21, 1'b0, 1'b0, 1'b0, 8'd2);
    pulse("R2", 1, 4'b0100, 4'b0100, 8'h21);
    irq[1] = 1'b1;
    step();
    expect_out("R2", 4'b0100, 4'b0100, 8'h21, 1'b0);
    step();
    expect_out("R9", 4'b0, 4'b0, 8'h00, 1'b0);  // held high, no second delivery
    step();
    expect_out("R9", 4'b0, 4'b0, 8'h00, 1'b0);
    irq[1] = 1'b0;
    step();
  endtask

  task automatic t_lowest();
    prio = {4'd9, 4'd7, 4'd3, 4'd5};          // cpu3..cpu0
    wr(2, 8'h30, 1'b0, 1'b1, 1'b0, 8'h0F);
    pulse("R3", 2, 4'b0010, 4'b0010, 8'h30);   // rot ptr -> 2
    wr(2, 8'h30, 1'b0, 1'b1, 1'b0, 8'h0D);
    pulse("R3", 2, 4'b0001, 4'b0001, 8'h30);   // rot ptr -> 1
    prio = {4'd9, 4'd7, 4'd3, 4'd8};
    pulse("R3", 2, 4'b0100, 4'b0100, 8'h30);   // rot ptr -> 3
  endtask

  task automatic t_ties();
    prio = {4'd2, 4'd2, 4'd2, 4'd2};
    wr(2, 8'h31, 1'b0, 1'b1, 1'b0, 8'h0F);
    pulse("R4", 2, 4'b0001, 4'b1000, 8'h31);   // ptr 3 -> 0
    pulse("R4", 2, 4'b0001, 4'b0001, 8'h31);   // ptr 0 -> 1
    pulse("R4", 2, 4'b0001, 4'b0010, 8'h31);   // ptr 1 -> 2
    wr(2, 8'h31, 1'b0, 1'b1, 1'b0, 8'h0A);
    pulse("R4", 2, 4'b0010, 4'b1000, 8'h31);   // ptr 2 -> 0
  endtask

  task automatic drop_one(input logic lp, input logic [7:0] d);
    wr(5, 8'h55, 1'b0, lp, 1'b0, d);
    irq[5] = 1'b1;
    step();
    expect_out("R7", 4'b0, 4'b0, 8'h00, 1'b1);
    irq[5] = 1'b0;
    step();
    expect_out("R7", 4'b0, 4'b0, 8'h00, 1'b0);
  endtask

  task automatic t_drop();
    drop_one(1'b0, 8'd4);
    drop_one(1'b0, 8'd200);
    drop_one(1'b1, 8'h00);
    drop_one(1'b1, 8'hF0);
    // rotation pointer unchanged by drops (still 0): tie on all four
    wr(2, 8'h32, 1'b0, 1'b1, 1'b0, 8'h0F);
    pulse("R4", 2, 4'b0001, 4'b0001, 8'h32);
  endtask

  task automatic t_mask();
    wr(6, 8'h66, 1'b1, 1'b0, 1'b0, 8'd0);
    irq[6] = 1'b1;
    step();
    expect_out("R6", 4'b0, 4'b0, 8'h00, 1'b0);
    irq[6] = 1'b0;
    step();
    wr(6, 8'h66, 1'b0, 1'b0, 1'b0, 8'd0);
    expect_out("R6", 4'b0, 4'b0, 8'h00, 1'b0);
    step();
    expect_out("R6", 4'b0, 4'b0, 8'h00, 1'b0);
    wr(6, 8'h66, 1'b1, 1'b0, 1'b1, 8'd0);
    irq[6] = 1'b1;
    step();
    step();
    expect_out("R6", 4'b0, 4'b0, 8'h00, 1'b0);
    irq[6] = 1'b0;
    step();
  endtask

  task automatic t_level();
    wr(3, 8'h40, 1'b0, 1'b0, 1'b1, 8'd1);
    wr(4, 8'h40, 1'b0, 1'b0, 1'b1, 8'd2);
    irq[3] = 1'b1; irq[4] = 1'b1;
    step();
    expect_out("R10", 4'b0010, 4'b0010, 8'h40, 1'b0);
    step();
    expect_out("R10", 4'b0100, 4'b0100, 8'h40, 1'b0);
    step();
    expect_out("R8", 4'b0, 4'b0, 8'h00, 1'b0);
    eoi = 1'b1; eoi_cpu = 2'd1; eoi_vec = 8'h41;   // wrong vector
    step();
    eoi = 1'b0;
    step();
    expect_out("R8", 4'b0, 4'b0, 8'h00, 1'b0);
    eoi = 1'b1; eoi_cpu = 2'd1; eoi_vec = 8'h40;
    step();
    eoi = 1'b0;
    expect_out("R8", 4'b0, 4'b0, 8'h00, 1'b0);
    step();
    expect_out("R8", 4'b0010, 4'b0010, 8'h40, 1'b0);  // line 3 still high
    step();
    expect_out("R11", 4'b0, 4'b0, 8'h00, 1'b0);       // line 4 still held
    irq[3] = 1'b0; irq[4] = 1'b0;
    eoi = 1'b1; eoi_cpu = 2'd2; eoi_vec = 8'h40;
    step();
    eoi = 1'b0;
    step();
    expect_out("R11", 4'b0, 4'b0, 8'h00, 1'b0);
  endtask

  task automatic t_order();
    wr(7, 8'h70, 1'b0, 1'b0, 1'b0, 8'd0);
    wr(8, 8'h80, 1'b0, 1'b0, 1'b0, 8'd3);
    irq[7] = 1'b1; irq[8] = 1'b1;
    step();
    expect_out("R10", 4'b0001, 4'b0001, 8'h70, 1'b0);
    step();
    expect_out("R10", 4'b1000, 4'b1000, 8'h80, 1'b0);
    step();
    expect_out("R9", 4'b0, 4'b0, 8'h00, 1'b0);
    irq[7] = 1'b0; irq[8] = 1'b0;
    step();
  endtask

  initial begin
    step();
    t_reset();
    t_fixed();
    t_lowest();
    t_ties();
    t_drop();
    t_mask();
    t_level();
    t_order();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog got=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule